// File: doc/BRIEF.md
# RTC Interrupt Emulation Sequencer

When the interrupt line of a real-time clock has been taken over by another timer, this block rebuilds the three classic clock interrupt kinds from one polling tick. The three kinds are the once-per-second update, the time-of-day alarm and the periodic interrupt. The tick runs at 2^POLL_LOG2 Hz, which is 64 Hz by default. On each tick the block samples the current hours, minutes and seconds, together with a count of ticks the tick source missed. From these it decides which of the three flags to raise. When at least one flag is raised, it emits a one-cycle strobe with a 16-bit status word.

The update and alarm events are found by sampling. The update flag fires when the sampled seconds differ from the seconds recorded on an earlier tick. The alarm flag fires when the sample equals the programmed alarm time. Periodic rates from 2 Hz up to the poll rate come from dividing the ticks. Missed ticks are credited to the divider while the periodic interrupt is enabled. For rates above the poll rate, `fast_interval` asks the tick source to run at the requested period, and every tick then raises the periodic flag.

The sequencer has four states:
- ST_IDLE: the tick channel is off.
- ST_ARMED: waiting for a tick, with the time sample latched on the tick.
- ST_EVAL: the flags are computed.
- ST_FIRE: the strobe is high.

Its transitions are:
- IDLE→ARMED when any enable is set.
- ARMED→IDLE when all enables are clear.
- ARMED→EVAL on a tick.
- EVAL→FIRE when a flag is raised.
- EVAL→ARMED when no flag is raised.
- FIRE→ARMED always.

Ticks must be at least three clock cycles apart. A tick that arrives outside ST_ARMED is not seen.

Top module: `rtcemu_seq`

## Requirements
- R1: After reset, `irq_strobe` is 0, `irq_word` is 0 and `tick_chan_en` is 0.
- R2: `tick_chan_en` is 1 from the cycle after any enable is set. It returns to 0 within four cycles after all three enables are cleared.
- R3: For a tick sampled at clock edge N that raises a flag, `irq_strobe` is high from edge N+1 to edge N+2 only, exactly one cycle long.
- R4: During the strobe the status word has these fields:
  - bit 4: update flag.
  - bit 5: alarm flag.
  - bit 6: periodic flag.
  - bit 7: summary bit, set to 1.
  - bits 15:8: interrupt count, equal to 1.
  - bits 3:0: 0.
- R5: A tick that raises no flag produces no strobe, and the word stays 0 whenever the strobe is low.
- R6: With `en_update` set, a tick whose seconds differ from the recorded seconds raises the update flag. The first tick after `en_update` rises only records the seconds.
- R7: With `en_alarm` set, a tick whose hours, minutes and seconds all equal the alarm time raises the alarm flag.
- R8: With `en_periodic` set and `rate_log2` = k ≤ POLL_LOG2, the periodic flag is raised on every 2^(POLL_LOG2−k)-th tick, and the tick counter then restarts from zero.
- R9: With `en_periodic` set and k > POLL_LOG2, `fast_interval` is 1 and every tick raises the periodic flag.
- R10: The `lost_ticks` value sampled with a tick is added to the tick counter only while `en_periodic` is set.
- R11: A change of `rate_log2` restarts the tick counter from zero.
- R12: With all enables clear, ticks produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poll_tick | input | 1 | One-cycle polling tick |
| lost_ticks | input | LOST_W | Ticks missed before this one, sampled with the tick |
| cur_hour | input | HR_W | Current hours |
| cur_min | input | MIN_W | Current minutes |
| cur_sec | input | SEC_W | Current seconds |
| alarm_hour | input | HR_W | Alarm hours |
| alarm_min | input | MIN_W | Alarm minutes |
| alarm_sec | input | SEC_W | Alarm seconds |
| en_update | input | 1 | Update interrupt enable |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_periodic | input | 1 | Periodic interrupt enable |
| rate_log2 | input | RATE_W | Requested periodic rate as log2 of Hz |
| irq_strobe | output | 1 | One-cycle interrupt strobe |
| irq_word | output | 16 | Status word, valid with the strobe |
| tick_chan_en | output | 1 | Tick channel on request |
| fast_interval | output | 1 | Tick source should use the requested period |

## Verification
The embedded properties hold on every cycle:
- The strobe never lasts two cycles.
- The word always carries the summary bit and the count of one while the strobe is high, and is zero otherwise.
- The periodic counter stays below its divide limit.
- A rising update enable leaves the recorded seconds invalid.
- The channel request drops after enables clear in the waiting state.

Several behaviours need a sequence of ticks, so only the directed scenarios can show them:
- the one-tick silence after enabling updates;
- the exact tick on which each divided rate fires;
- the credit of missed ticks, and its absence while periodic interrupts are off;
- the restart of the counter on a rate change.

// File: rtl/rtcemu_pkg.sv
package rtcemu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_EVAL,
        ST_FIRE
    } seq_state_e;

    localparam int FLAG_UPDATE   = 4;
    localparam int FLAG_ALARM    = 5;
    localparam int FLAG_PERIODIC = 6;
    localparam int FLAG_SUMMARY  = 7;
    localparam logic [7:0] IRQ_COUNT = 8'd1;

endpackage

// File: rtl/rtcemu_update_det.sv
module rtcemu_update_det #(
    parameter int SEC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval,
    input  logic             enable,
    input  logic [SEC_W-1:0] sec,
    output logic             uf
);

    logic [SEC_W-1:0] prev_sec_q;
    logic             valid_q;
    logic             en_q;
    logic             differs;

    assign differs = !valid_q || (sec != prev_sec_q);
    assign uf      = eval && enable && valid_q && (sec != prev_sec_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_sec_q <= '0;
            valid_q    <= 1'b0;
            en_q       <= 1'b0;
        end else begin
            en_q <= enable;
            if (eval && enable && differs) begin
                prev_sec_q <= sec;
                valid_q    <= 1'b1;
            end
            // a fresh enable marks the recorded seconds as unknown
            if (enable && !en_q) begin
                valid_q <= 1'b0;
            end
        end
    end

    // R6: the record is invalid right after update interrupts are enabled
    assert_invalid_after_enable_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (enable && !en_q) |=> !valid_q
    );

endmodule

// File: rtl/rtcemu_alarm_cmp.sv
module rtcemu_alarm_cmp #(
    parameter int HR_W  = 5,
    parameter int MIN_W = 6,
    parameter int SEC_W = 6
) (
    input  logic             eval,
    input  logic             enable,
    input  logic [HR_W-1:0]  hour,
    input  logic [MIN_W-1:0] minute,
    input  logic [SEC_W-1:0] sec,
    input  logic [HR_W-1:0]  al_hour,
    input  logic [MIN_W-1:0] al_min,
    input  logic [SEC_W-1:0] al_sec,
    output logic             af
);

    logic match;

    always_comb begin
        match = (hour == al_hour) && (minute == al_min) && (sec == al_sec);
        af    = eval && enable && match;
    end

endmodule

// File: rtl/rtcemu_periodic_div.sv
module rtcemu_periodic_div #(
    parameter int POLL_LOG2 = 6,
    parameter int RATE_W    = 4,
    parameter int LOST_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval,
    input  logic              enable,
    input  logic [RATE_W-1:0] rate_log2,
    input  logic [LOST_W-1:0] lost,
    output logic              pf,
    output logic              fast
);

    localparam int WIDEST = (POLL_LOG2 > LOST_W) ? POLL_LOG2 : LOST_W;
    localparam int SUM_W  = WIDEST + 2;

    logic [SUM_W-1:0]  cnt_q;
    logic [SUM_W-1:0]  limit;
    logic [SUM_W-1:0]  base;
    logic [SUM_W-1:0]  sum;
    logic [RATE_W-1:0] rate_q;
    logic              rate_changed;
    logic              above_poll;

    assign rate_changed = (rate_log2 != rate_q);
    assign above_poll   = int'(rate_log2) > POLL_LOG2;

    always_comb begin
        if (above_poll) begin
            limit = SUM_W'(1);
        end else begin
            limit = SUM_W'(1) << (POLL_LOG2 - int'(rate_log2));
        end
        base = rate_changed ? '0 : cnt_q;
        sum  = base + SUM_W'(1) + SUM_W'(lost);
        pf   = eval && enable && (sum >= limit);
        fast = enable && above_poll;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rate_q <= '0;
        end else begin
            rate_q <= rate_log2;
            if (eval && enable) begin
                cnt_q <= pf ? '0 : sum;
            end else if (rate_changed) begin
                cnt_q <= '0;
            end
        end
    end

    // R8: the tick counter never reaches the divide limit of a steady rate
    assert_count_below_limit_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (rate_log2 == rate_q) |-> (cnt_q < limit)
    );

endmodule

// File: rtl/rtcemu_seq.sv
module rtcemu_seq
    import rtcemu_pkg::*;
#(
    parameter int POLL_LOG2 = 6,
    parameter int RATE_W    = 4,
    parameter int LOST_W    = 4,
    parameter int HR_W      = 5,
    parameter int MIN_W     = 6,
    parameter int SEC_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_tick,
    input  logic [LOST_W-1:0] lost_ticks,
    input  logic [HR_W-1:0]   cur_hour,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [HR_W-1:0]   alarm_hour,
    input  logic [MIN_W-1:0]  alarm_min,
    input  logic [SEC_W-1:0]  alarm_sec,
    input  logic              en_update,
    input  logic              en_alarm,
    input  logic              en_periodic,
    input  logic [RATE_W-1:0] rate_log2,
    output logic              irq_strobe,
    output logic [15:0]       irq_word,
    output logic              tick_chan_en,
    output logic              fast_interval
);

    seq_state_e state_q, state_n;

    logic [HR_W-1:0]   samp_hour;
    logic [MIN_W-1:0]  samp_min;
    logic [SEC_W-1:0]  samp_sec;
    logic [LOST_W-1:0] samp_lost;
    logic [15:0]       word_q;
    logic [15:0]       word_n;
    logic              any_en;
    logic              eval;
    logic              uf, af, pf, any_flag;

    assign any_en   = en_update || en_alarm || en_periodic;
    assign eval     = (state_q == ST_EVAL);
    assign any_flag = uf || af || pf;

    rtcemu_update_det #(.SEC_W(SEC_W)) u_update (
        .clk    (clk),
        .rst_n  (rst_n),
        .eval   (eval),
        .enable (en_update),
        .sec    (samp_sec),
        .uf     (uf)
    );

    rtcemu_alarm_cmp #(.HR_W(HR_W), .MIN_W(MIN_W), .SEC_W(SEC_W)) u_alarm (
        .eval    (eval),
        .enable  (en_alarm),
        .hour    (samp_hour),
        .minute  (samp_min),
        .sec     (samp_sec),
        .al_hour (alarm_hour),
        .al_min  (alarm_min),
        .al_sec  (alarm_sec),
        .af      (af)
    );

    rtcemu_periodic_div #(
        .POLL_LOG2 (POLL_LOG2),
        .RATE_W    (RATE_W),
        .LOST_W    (LOST_W)
    ) u_periodic (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval      (eval),
        .enable    (en_periodic),
        .rate_log2 (rate_log2),
        .lost      (samp_lost),
        .pf        (pf),
        .fast      (fast_interval)
    );

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_en) state_n = ST_ARMED;
            end
            ST_ARMED: begin
                if (!any_en)        state_n = ST_IDLE;
                else if (poll_tick) state_n = ST_EVAL;
            end
            ST_EVAL: begin
                state_n = any_flag ? ST_FIRE : ST_ARMED;
            end
            ST_FIRE: begin
                state_n = ST_ARMED;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // status word assembly
    always_comb begin
        word_n = '0;
        if (state_n == ST_FIRE) begin
            word_n[15:8]          = IRQ_COUNT;
            word_n[FLAG_SUMMARY]  = 1'b1;
            word_n[FLAG_PERIODIC] = pf;
            word_n[FLAG_ALARM]    = af;
            word_n[FLAG_UPDATE]   = uf;
        end
    end

    // outputs and tick sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q    <= '0;
            samp_hour <= '0;
            samp_min  <= '0;
            samp_sec  <= '0;
            samp_lost <= '0;
        end else begin
            word_q <= word_n;
            if (state_q == ST_ARMED && any_en && poll_tick) begin
                samp_hour <= cur_hour;
                samp_min  <= cur_min;
                samp_sec  <= cur_sec;
                samp_lost <= lost_ticks;
            end
        end
    end

    assign irq_strobe   = (state_q == ST_FIRE);
    assign irq_word     = word_q;
    assign tick_chan_en = (state_q != ST_IDLE);

    // R3: the strobe is a single cycle
    assert_single_strobe_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        irq_strobe |=> !irq_strobe
    );

    // R4: a strobe always carries summary bit, count one and some flag
    assert_word_format_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        irq_strobe |-> (irq_word[FLAG_SUMMARY] && irq_word[15:8] == IRQ_COUNT
                        && irq_word[3:0] == 4'd0 && (|irq_word[6:4]))
    );

    // R5: no word content outside a strobe
    assert_word_quiet_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        !irq_strobe |-> (irq_word == 16'd0)
    );

    // R2: the channel request drops once waiting with every enable clear
    assert_chan_off_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && !any_en) |=> !tick_chan_en
    );

endmodule

// File: tb/rtcemu_seq_tb.sv
`timescale 1ns/1ps
module rtcemu_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        poll_tick = 1'b0;
    logic [3:0]  lost_ticks = '0;
    logic [4:0]  cur_hour = '0;
    logic [5:0]  cur_min = '0;
    logic [5:0]  cur_sec = '0;
    logic [4:0]  alarm_hour = '0;
    logic [5:0]  alarm_min = '0;
    logic [5:0]  alarm_sec = '0;
    logic        en_update = 1'b0;
    logic        en_alarm = 1'b0;
    logic        en_periodic = 1'b0;
    logic [3:0]  rate_log2 = 4'd4;
    logic        irq_strobe;
    logic [15:0] irq_word;
    logic        tick_chan_en;
    logic        fast_interval;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtcemu_seq u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .poll_tick     (poll_tick),
        .lost_ticks    (lost_ticks),
        .cur_hour      (cur_hour),
        .cur_min       (cur_min),
        .cur_sec       (cur_sec),
        .alarm_hour    (alarm_hour),
        .alarm_min     (alarm_min),
        .alarm_sec     (alarm_sec),
        .en_update     (en_update),
        .en_alarm      (en_alarm),
        .en_periodic   (en_periodic),
        .rate_log2     (rate_log2),
        .irq_strobe    (irq_strobe),
        .irq_word      (irq_word),
        .tick_chan_en  (tick_chan_en),
        .fast_interval (fast_interval)
    );

    localparam logic [15:0] W_UPD = 16'h0190;
    localparam logic [15:0] W_ALM = 16'h01A0;
    localparam logic [15:0] W_PER = 16'h01C0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // drive one tick, sample strobe/word one cycle after the evaluation edge
    task automatic tick(input logic [4:0] h, input logic [5:0] m, input logic [5:0] s,
                        input logic [3:0] lost, output logic stb, output logic [15:0] w,
                        output logic stb_after);
        @(negedge clk);
        cur_hour = h; cur_min = m; cur_sec = s; lost_ticks = lost; poll_tick = 1'b1;
        @(negedge clk);
        poll_tick = 1'b0; lost_ticks = '0;
        @(negedge clk);
        stb = irq_strobe; w = irq_word;
        @(negedge clk);
        stb_after = irq_strobe;
    endtask

    task automatic expect_tick(input string req, input logic [4:0] h, input logic [5:0] m,
                               input logic [5:0] s, input logic [3:0] lost, input logic [15:0] exp_w);
        logic stb, stb_after;
        logic [15:0] w;
        tick(h, m, s, lost, stb, w, stb_after);
        check(req, {31'd0, stb}, {31'd0, exp_w != 16'd0});
        check(req, {16'd0, w}, {16'd0, exp_w});
    endtask

    task automatic t_reset();
        check("R1 strobe", {31'd0, irq_strobe}, 32'd0);
        check("R1 word", {16'd0, irq_word}, 32'd0);
        check("R1 chan", {31'd0, tick_chan_en}, 32'd0);
    endtask

    task automatic t_channel();
        @(negedge clk); en_update = 1'b1;
        @(negedge clk);
        check("R2 chan on", {31'd0, tick_chan_en}, 32'd1);
        en_update = 1'b0;
        wait_cycles(4);
        check("R2 chan off", {31'd0, tick_chan_en}, 32'd0);
    endtask

    task automatic t_update();
        logic stb, stb_after;
        logic [15:0] w;
        @(negedge clk); en_update = 1'b1;
        wait_cycles(2);
        expect_tick("R6 first tick records only", 5'd1, 6'd2, 6'd10, 4'd0, 16'd0);
        expect_tick("R5 same second silent", 5'd1, 6'd2, 6'd10, 4'd0, 16'd0);
        tick(5'd1, 6'd2, 6'd11, 4'd0, stb, w, stb_after);
        check("R3 strobe after tick", {31'd0, stb}, 32'd1);
        check("R3 strobe one cycle", {31'd0, stb_after}, 32'd0);
        check("R4 R6 update word", {16'd0, w}, {16'd0, W_UPD});
    endtask

    task automatic t_alarm();
        @(negedge clk);
        en_update = 1'b0; en_alarm = 1'b1;
        alarm_hour = 5'd12; alarm_min = 6'd34; alarm_sec = 6'd56;
        expect_tick("R7 near miss", 5'd12, 6'd34, 6'd55, 4'd0, 16'd0);
        expect_tick("R7 alarm match", 5'd12, 6'd34, 6'd56, 4'd0, W_ALM);
        expect_tick("R7 minute differs", 5'd12, 6'd35, 6'd56, 4'd0, 16'd0);
    endtask

    task automatic restart_counter();
        @(negedge clk); rate_log2 = 4'd5;
        wait_cycles(2);
        rate_log2 = 4'd4;
        wait_cycles(2);
    endtask

    task automatic t_periodic();
        restart_counter();
        en_alarm = 1'b0; en_periodic = 1'b1;
        for (int rep = 0; rep < 2; rep++) begin
            for (int k = 0; k < 3; k++) expect_tick("R8 divide silent", 5'd1, 6'd1, 6'd1, 4'd0, 16'd0);
            expect_tick("R8 16Hz fourth tick", 5'd1, 6'd1, 6'd1, 4'd0, W_PER);
        end
        check("R9 slow rate not fast", {31'd0, fast_interval}, 32'd0);
    endtask

    task automatic t_lost();
        expect_tick("R10 lost credit partial", 5'd1, 6'd1, 6'd1, 4'd2, 16'd0);
        expect_tick("R10 lost credit fires", 5'd1, 6'd1, 6'd1, 4'd0, W_PER);
        @(negedge clk); en_periodic = 1'b0; en_alarm = 1'b1;
        expect_tick("R10 disabled no strobe", 5'd1, 6'd1, 6'd1, 4'd3, 16'd0);
        expect_tick("R10 disabled no strobe", 5'd1, 6'd1, 6'd1, 4'd3, 16'd0);
        @(negedge clk); en_periodic = 1'b1; en_alarm = 1'b0;
        for (int k = 0; k < 3; k++) expect_tick("R10 lost ignored while off", 5'd1, 6'd1, 6'd1, 4'd0, 16'd0);
        expect_tick("R10 fourth tick after re-enable", 5'd1, 6'd1, 6'd1, 4'd0, W_PER);
    endtask

    task automatic t_rate_change();
        expect_tick("R11 pre-change tick", 5'd1, 6'd1, 6'd1, 4'd0, 16'd0);
        expect_tick("R11 pre-change tick", 5'd1, 6'd1, 6'd1, 4'd0, 16'd0);
        restart_counter();
        for (int k = 0; k < 3; k++) expect_tick("R11 counter restarted", 5'd1, 6'd1, 6'd1, 4'd0, 16'd0);
        expect_tick("R11 fires after four", 5'd1, 6'd1, 6'd1, 4'd0, W_PER);
    endtask

    task automatic t_fast();
        @(negedge clk); rate_log2 = 4'd9;
        @(negedge clk);
        check("R9 fast interval", {31'd0, fast_interval}, 32'd1);
        for (int k = 0; k < 3; k++) expect_tick("R9 every tick", 5'd1, 6'd1, 6'd1, 4'd0, W_PER);
    endtask

    task automatic t_combo();
        @(negedge clk);
        en_update = 1'b1; en_alarm = 1'b1;
        alarm_hour = 5'd0; alarm_min = 6'd0; alarm_sec = 6'd21;
        expect_tick("R4 periodic only", 5'd0, 6'd0, 6'd20, 4'd0, W_PER);
        expect_tick("R4 all three flags", 5'd0, 6'd0, 6'd21, 4'd0, 16'h01F0);
    endtask

    task automatic t_quiet();
        logic stb, stb_after;
        logic [15:0] w;
        @(negedge clk);
        en_update = 1'b0; en_alarm = 1'b0; en_periodic = 1'b0;
        wait_cycles(4);
        check("R12 chan off", {31'd0, tick_chan_en}, 32'd0);
        check("R12 fast off", {31'd0, fast_interval}, 32'd0);
        tick(5'd0, 6'd0, 6'd22, 4'd0, stb, w, stb_after);
        check("R12 no strobe", {31'd0, stb}, 32'd0);
        check("R12 no word", {16'd0, w}, 32'd0);
    endtask

    initial begin
        wait_cycles(3);
        t_reset();
        rst_n = 1'b1;
        wait_cycles(2);
        t_reset();
        t_channel();
        t_update();
        t_alarm();
        t_periodic();
        t_lost();
        t_rate_change();
        t_fast();
        t_combo();
        t_quiet();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule